// File: doc/BRIEF.md
# Trilinear Histogram Weight Generator

This datapath takes one gradient sample's magnitude and its three fractional offsets (row, column and orientation) inside a descriptor cell. It produces the eight weights that spread that sample over the neighbouring bins by trilinear interpolation. Every weight is the magnitude times one factor per dimension, and each factor is either the offset d or its complement 1-d.

Only eight multipliers are built. In the first pass, six of them form two magnitude-by-row products and four column-by-orientation products, and these are registered. In the second pass, an operand routing matrix feeds the registered partial products back, and all eight multipliers form the final weights. An operation therefore occupies the multipliers for two cycles, and a new one can start every second cycle.

Top module: `trw_weight_gen`

## Requirements
- R1: Offsets are unsigned fractions with DW fraction bits (default 8). The complement of an offset d is 2^DW - d, and it saturates to 2^DW - 1 (255) when d is 0.
- R2: The weight in slot i (bits i*DW+DW-1 down to i*DW of w_o) uses the complement of the row offset when bit 2 of i is set, the complement of the column offset when bit 1 is set, and the complement of the orientation offset when bit 0 is set. Slot 0 therefore uses (d_r, d_c, d_o) and slot 7 uses all three complements.
- R3: Each product keeps its upper DW bits. With r, c and o the factors chosen for a slot, the weight is ((mag·r >> DW) · (c·o >> DW)) >> DW.
- R4: An operation is issued when start_i is high and busy_o is low at a rising clock edge. busy_o is high for the following cycle only. done_o is then high for exactly one cycle, and all eight weights on w_o are valid in that cycle.
- R5: A start_i request while busy_o is high is ignored. It produces no later busy_o or done_o and does not alter the weights of the operation in flight.
- R6: A request in the cycle where done_o is high is accepted, so operations can be issued every second cycle.
- R7: w_o holds its value from one done_o pulse until the next one.
- R8: After reset, busy_o and done_o are low and w_o is zero.
- R9: The inputs are sampled only in the issue cycle. Changing mag_i or the offsets while busy_o is high does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue request |
| mag_i | input | DW | Gradient magnitude |
| d_r_i | input | DW | Row fractional offset |
| d_c_i | input | DW | Column fractional offset |
| d_o_i | input | DW | Orientation fractional offset |
| w_o | output | 8*DW | Eight weights, slot i at bits i*DW+DW-1 down to i*DW |
| busy_o | output | 1 | Second pass in progress; requests are ignored |
| done_o | output | 1 | One-cycle pulse when w_o is updated |

## Verification
The checker watches the issue handshake on every cycle. It checks that busy_o lasts a single cycle, that done_o follows busy_o and only busy_o, that ignored requests start nothing, and that w_o stays still outside done_o pulses. The numerical content of the weights cannot be checked that way. The bench checks it: saturated complements, zero and full-scale magnitude, the slot ordering, and results after inputs were disturbed during the busy cycle, each computed with the staged truncation formula.

// File: rtl/trw_pkg.sv
package trw_pkg;
  localparam int unsigned NUM_W  = 8;  // weights per sample (2^3 dims)
  localparam int unsigned NUM_P1 = 6;  // partial products kept after pass one
  localparam int unsigned NUM_D  = 3;  // interpolated dimensions
endpackage

// File: rtl/trw_comp.sv
module trw_comp #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] c_o
);
  logic [DW:0] diff;
  assign diff = {1'b1, {DW{1'b0}}} - {1'b0, d_i};
  // 1.0 is not representable: saturate
  assign c_o  = (d_i == '0) ? {DW{1'b1}} : diff[DW-1:0];
endmodule

// File: rtl/trw_mul.sv
module trw_mul #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] p_o
);
  logic [2*DW-1:0] full;
  assign full = a_i * b_i;
  assign p_o  = full[2*DW-1:DW];
endmodule

// File: rtl/trw_ctrl.sv
module trw_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic busy_o,
  output logic done_o
);
  assign accept_o = start_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      busy_o <= accept_o;
      done_o <= busy_o;
    end
  end
endmodule

// File: rtl/trw_route.sv
module trw_route
  import trw_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                   pass2_i,
  input  logic [DW-1:0]          mag_i,
  input  logic [DW-1:0]          dr_i,
  input  logic [DW-1:0]          dc_i,
  input  logic [DW-1:0]          do_i,
  input  logic [DW-1:0]          cr_i,
  input  logic [DW-1:0]          cc_i,
  input  logic [DW-1:0]          co_i,
  input  logic [NUM_P1*DW-1:0]   p1_i,
  output logic [NUM_W*DW-1:0]    op_a_o,
  output logic [NUM_W*DW-1:0]    op_b_o
);
  // p1 slots: 0 mag*dr, 1 mag*cr, 2 dc*do, 3 dc*co, 4 cc*do, 5 cc*co
  for (genvar k = 0; k < NUM_W; k++) begin : g_mux
    logic [DW-1:0] a1, b1, a2, b2;
    localparam int unsigned RSEL = (k >> 2) & 1;
    localparam int unsigned QSEL = 2 + (k & 3);

    if (k == 0) begin : g_k0
      assign a1 = mag_i; assign b1 = dr_i;
    end else if (k == 1) begin : g_k1
      assign a1 = mag_i; assign b1 = cr_i;
    end else if (k == 2) begin : g_k2
      assign a1 = dc_i;  assign b1 = do_i;
    end else if (k == 3) begin : g_k3
      assign a1 = dc_i;  assign b1 = co_i;
    end else if (k == 4) begin : g_k4
      assign a1 = cc_i;  assign b1 = do_i;
    end else if (k == 5) begin : g_k5
      assign a1 = cc_i;  assign b1 = co_i;
    end else begin : g_idle
      assign a1 = '0;    assign b1 = '0;
    end

    assign a2 = p1_i[RSEL*DW +: DW];
    assign b2 = p1_i[QSEL*DW +: DW];

    assign op_a_o[k*DW +: DW] = pass2_i ? a2 : a1;
    assign op_b_o[k*DW +: DW] = pass2_i ? b2 : b1;
  end
endmodule

// File: rtl/trw_weight_gen.sv
module trw_weight_gen
  import trw_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DW-1:0]     mag_i,
  input  logic [DW-1:0]     d_r_i,
  input  logic [DW-1:0]     d_c_i,
  input  logic [DW-1:0]     d_o_i,
  output logic [8*DW-1:0]   w_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned WBITS = NUM_W * DW;
  localparam int unsigned PBITS = NUM_P1 * DW;

  logic              accept;
  logic [DW-1:0]     cr, cc, co;
  logic [PBITS-1:0]  p1_q;
  logic [WBITS-1:0]  op_a, op_b, prod;
  logic [WBITS-1:0]  w_q;

  trw_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  trw_comp #(.DW(DW)) u_cr (.d_i(d_r_i), .c_o(cr));
  trw_comp #(.DW(DW)) u_cc (.d_i(d_c_i), .c_o(cc));
  trw_comp #(.DW(DW)) u_co (.d_i(d_o_i), .c_o(co));

  trw_route #(.DW(DW)) u_route (
    .pass2_i (busy_o),
    .mag_i   (mag_i),
    .dr_i    (d_r_i),
    .dc_i    (d_c_i),
    .do_i    (d_o_i),
    .cr_i    (cr),
    .cc_i    (cc),
    .co_i    (co),
    .p1_i    (p1_q),
    .op_a_o  (op_a),
    .op_b_o  (op_b)
  );

  for (genvar k = 0; k < NUM_W; k++) begin : g_mul
    trw_mul #(.DW(DW)) u_mul (
      .a_i (op_a[k*DW +: DW]),
      .b_i (op_b[k*DW +: DW]),
      .p_o (prod[k*DW +: DW])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= '0;
    end else if (accept) begin
      p1_q <= prod[PBITS-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q <= '0;
    end else if (busy_o) begin
      w_q <= prod;
    end
  end

  assign w_o = w_q;
endmodule

// File: rtl/trw_checker.sv
module trw_checker #(
  parameter int unsigned DW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [8*DW-1:0] w_o,
  input logic            busy_o,
  input logic            done_o
);
  AST_ISSUE_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);  // R4
  AST_BUSY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);  // R4
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> done_o);  // R4
  AST_NO_SPURIOUS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i || busy_o) |=> !busy_o);  // R5
  AST_DONE_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !done_o);  // R5
  AST_W_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(w_o));  // R7
endmodule

bind trw_weight_gen trw_checker #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .w_o     (w_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/tb_trw_weight_gen.sv
module tb_trw_weight_gen;
  localparam int DW = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [DW-1:0]   mag_i = '0, d_r_i = '0, d_c_i = '0, d_o_i = '0;
  logic [8*DW-1:0] w_o;
  logic            busy_o, done_o;

  int checks = 0;
  int errors = 0;

  trw_weight_gen #(.DW(DW)) dut (
    .clk_i, .rst_ni, .start_i, .mag_i, .d_r_i, .d_c_i, .d_o_i,
    .w_o, .busy_o, .done_o
  );

  always #10 clk_i = ~clk_i;

  function automatic int cmp(int d);
    return (d == 0) ? 255 : 256 - d;
  endfunction

  function automatic int exp_w(int m, int dr, int dc, int dq, int i);
    int r, c, o, a, b;
    r = i[2] ? cmp(dr) : dr;
    c = i[1] ? cmp(dc) : dc;
    o = i[0] ? cmp(dq) : dq;
    a = (m * r) >> 8;
    b = (c * o) >> 8;
    return (a * b) >> 8;
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic chk_weights(string req, int m, int dr, int dc, int dq);
    for (int i = 0; i < 8; i++)
      chk(req, int'(w_o[i*DW +: DW]), exp_w(m, dr, dc, dq, i));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one operation; disturb=1 keeps start high with other inputs during busy
  task automatic run_op(string req, int m, int dr, int dc, int dq, bit disturb);
    @(negedge clk_i);
    start_i = 1'b1; mag_i = m[7:0]; d_r_i = dr[7:0]; d_c_i = dc[7:0]; d_o_i = dq[7:0];
    @(negedge clk_i);
    chk({req, " R4 busy"}, busy_o, 1);
    chk({req, " R4 no early done"}, done_o, 0);
    if (disturb) begin
      mag_i = ~mag_i; d_r_i = 8'd3; d_c_i = 8'd200; d_o_i = 8'd0;
    end else begin
      start_i = 1'b0;
    end
    @(negedge clk_i);
    start_i = 1'b0;
    chk({req, " R4 done"}, done_o, 1);
    chk({req, " R4 busy clear"}, busy_o, 0);
    chk_weights({req, " R3"}, m, dr, dc, dq);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R8 busy", busy_o, 0);
    chk("R8 done", done_o, 0);
    chk("R8 w", (w_o == '0) ? 1 : 0, 1);
  endtask

  task automatic t_basic();
    run_op("basic", 200, 64, 128, 32, 1'b0);
    run_op("half", 255, 128, 128, 128, 1'b0);
    run_op("zero mag R3", 0, 17, 99, 250, 1'b0);
  endtask

  task automatic t_saturate();
    // R1: all offsets zero -> complement 255, slot 7 = (254*254)>>8 = 252
    run_op("R1 sat", 255, 0, 0, 0, 1'b0);
    chk("R1 slot7", int'(w_o[7*DW +: DW]), 252);
    chk("R1 slot0", int'(w_o[0 +: DW]), 0);
  endtask

  task automatic t_order();
    // R2: only row offset nonzero; slots with bit2 clear use d_r
    run_op("R2 order", 255, 255, 0, 0, 1'b0);
    chk("R2 slot3", int'(w_o[3*DW +: DW]), ((((255*255)>>8) * ((255*255)>>8)) >> 8));
    chk("R2 slot7", int'(w_o[7*DW +: DW]), ((((255*1)>>8) * ((255*255)>>8)) >> 8));
    run_op("R2 mixed", 240, 16, 224, 80, 1'b0);
  endtask

  task automatic t_ignore();
    // R5 and R9: start held with disturbed inputs during busy
    run_op("R5 R9 ignore", 180, 40, 90, 160, 1'b1);
    @(negedge clk_i);
    chk("R5 no second busy", busy_o, 0);
    chk("R5 no second done", done_o, 0);
    chk_weights("R9 held", 180, 40, 90, 160);
  endtask

  task automatic t_back2back();
    // R6: issue in the done cycle
    @(negedge clk_i);
    start_i = 1'b1; mag_i = 8'd100; d_r_i = 8'd10; d_c_i = 8'd20; d_o_i = 8'd30;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    chk("R6 first done", done_o, 1);
    chk_weights("R6 first", 100, 10, 20, 30);
    start_i = 1'b1; mag_i = 8'd250; d_r_i = 8'd245; d_c_i = 8'd5; d_o_i = 8'd129;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R6 accepted", busy_o, 1);
    @(negedge clk_i);
    chk("R6 second done", done_o, 1);
    chk_weights("R6 second", 250, 245, 5, 129);
  endtask

  task automatic t_hold();
    // R7: idle cycles with changing inputs leave w_o unchanged
    for (int n = 0; n < 4; n++) begin
      @(negedge clk_i);
      mag_i = 8'(n * 37); d_r_i = 8'(n * 11);
      chk("R7 done low", done_o, 0);
      chk_weights("R7 hold", 250, 245, 5, 129);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_saturate();
    t_order();
    t_ignore();
    t_back2back();
    t_hold();
    repeat (2) @(negedge clk_i);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule